// File: doc/BRIEF.md
# Colour Sensor Bring-Up and Acquisition Sequencer

This block is the host-side controller for a small RGB colour sensor that is reached through a register-oriented two-wire bus. It does not drive the bus itself. It hands single-register commands (write register with a byte, or read register) to a separate bus master engine and waits for that engine to report completion. A pulse on `start_i` runs one measurement. The first run drives the sensor's active-low reset pin, writes the fixed setup values and then does what every later run does: program the per-channel sensitivity, trigger a conversion, poll the acquisition register until the sensor clears it, and read the three channel results.

Later runs skip the reset pulse and the setup writes, because the sensor keeps them. The sensitivity inputs (photodiode size and integration slot per channel) and the polling limit are captured when a run is accepted, so the caller may change them while a run is in flight. The three results are published together, with a one-cycle valid strobe. If the sensor never clears the acquisition register within the limit, the run ends with a one-cycle timeout strobe instead.

Top module: `rgb_sense_ctrl`

## Requirements
- R1: While `rst_n` is low, `sensor_rst_n_o`, `cmd_start_o`, `rgb_valid_o`, `timeout_o`, `red_o`, `green_o` and `blue_o` are all 0.
- R2: On the first accepted run, `sensor_rst_n_o` stays 0 for `RST_HOLD_CYCLES` further clock cycles after the accepting edge, then rises. No command is issued while it is 0, and the first request appears in the same cycle that it rises.
- R3: The first run starts with five writes of 0x01, to registers 0x03, 0x04, 0x0C, 0x0D and 0x0E in that order.
- R4: Every run writes the photodiode-size bytes to 0x0B (red), 0x0A (green) and 0x09 (blue), then the integration bytes to 0x11 (red), 0x10 (green) and 0x0F (blue). The values are those on the inputs at the edge where the run was accepted.
- R5: After the sensitivity writes, the block writes 0x02 to register 0x02. It then reads register 0x02 repeatedly until a read returns 0x00.
- R6: A run makes at most `poll_limit_i` reads of register 0x02 (the limit is captured at acceptance; 0 acts as 1). If the last allowed read is still nonzero, `timeout_o` is 1 for the single cycle after that completion. No channel read follows, and the colour outputs keep their values.
- R7: After a successful poll, the block reads 0x44, 0x43 and 0x42 in that order. In the cycle after the last of these completes, `red_o`, `green_o` and `blue_o` take the three bytes together and `rgb_valid_o` is 1 for that one cycle. At all other times the colour outputs hold their values.
- R8: `cmd_start_o` is a one-cycle request. `cmd_write_o` (1 = write, 0 = read), `cmd_addr_o` and `cmd_wdata_o` describe it and stay stable until `cmd_done_i`. No new request is made before then. A non-final completion yields the next request in the following cycle. A `cmd_done_i` pulse with no request outstanding has no effect.
- R9: Runs after the setup writes have completed begin with the sensitivity writes in the cycle after acceptance, and `sensor_rst_n_o` stays 1.
- R10: `start_i` is ignored while a run is in progress. It is accepted in the cycle where `rgb_valid_o` or `timeout_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request one measurement run |
| poll_limit_i | input | POLL_W | Maximum reads of the acquisition register per run |
| pd_size_r_i | input | 8 | Red photodiode size code |
| pd_size_g_i | input | 8 | Green photodiode size code |
| pd_size_b_i | input | 8 | Blue photodiode size code |
| int_time_r_i | input | 8 | Red integration slot code |
| int_time_g_i | input | 8 | Green integration slot code |
| int_time_b_i | input | 8 | Blue integration slot code |
| cmd_start_o | output | 1 | One-cycle request to the bus engine |
| cmd_write_o | output | 1 | 1 = register write, 0 = register read |
| cmd_addr_o | output | 8 | Sensor register address |
| cmd_wdata_o | output | 8 | Byte to write |
| cmd_done_i | input | 1 | Engine completion pulse |
| cmd_rdata_i | input | 8 | Byte read, valid with `cmd_done_i` |
| sensor_rst_n_o | output | 1 | Active-low reset to the sensor |
| red_o | output | 8 | Published red result |
| green_o | output | 8 | Published green result |
| blue_o | output | 8 | Published blue result |
| rgb_valid_o | output | 1 | One-cycle strobe when new results are published |
| timeout_o | output | 1 | One-cycle strobe when polling gives up |

## Verification
Two events can land in the same cycle: the end of one run (its valid or timeout strobe) and the acceptance of the next `start_i`. The bench holds `start_i` high across the end of a run, so a new run must begin in the cycle of the strobe. It also raises `start_i` in the middle of a run, where it must be ignored. A behavioural model predicts, cycle by cycle, when each request should appear and what command it carries. It also predicts the reset pin level and the strobes. The bench judges both cases by matching every output against that model on every clock.

// File: rtl/rgb_sense_pkg.sv
`timescale 1ns/1ps
package rgb_sense_pkg;

  localparam int DATA_W = 8;
  localparam int NUM_CH = 3;
  localparam int STEP_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RST   = 2'd1,
    ST_ISSUE = 2'd2,
    ST_WAIT  = 2'd3
  } seq_state_t;

  // Step numbering: setup 0..4, size 5..7, integration 8..10,
  // trigger 11, poll 12, channel reads 13..15.
  localparam logic [STEP_W-1:0] STEP_SIZE0 = 4'd5;
  localparam logic [STEP_W-1:0] STEP_TINT0 = 4'd8;
  localparam logic [STEP_W-1:0] STEP_TRIG  = 4'd11;
  localparam logic [STEP_W-1:0] STEP_POLL  = 4'd12;
  localparam logic [STEP_W-1:0] STEP_RD0   = 4'd13;
  localparam logic [STEP_W-1:0] STEP_LAST  = 4'd15;

  localparam logic [DATA_W-1:0] REG_ACQ     = 8'h02;
  localparam logic [DATA_W-1:0] ACQ_GO      = 8'h02;
  localparam logic [DATA_W-1:0] SETUP_VAL   = 8'h01;
  localparam logic [DATA_W-1:0] REG_SIZE_R  = 8'h0B;
  localparam logic [DATA_W-1:0] REG_TINT_R  = 8'h11;
  localparam logic [DATA_W-1:0] REG_RES_R   = 8'h44;

  typedef logic [NUM_CH-1:0][DATA_W-1:0] chan_bytes_t;

  typedef struct packed {
    logic              wr;
    logic [DATA_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } seq_cmd_t;

  function automatic logic [DATA_W-1:0] setup_addr(input logic [2:0] idx);
    case (idx)
      3'd0:    setup_addr = 8'h03;
      3'd1:    setup_addr = 8'h04;
      3'd2:    setup_addr = 8'h0C;
      3'd3:    setup_addr = 8'h0D;
      default: setup_addr = 8'h0E;
    endcase
  endfunction

endpackage

// File: rtl/rgb_sense_rst_timer.sv
`timescale 1ns/1ps
module rgb_sense_rst_timer #(
  parameter int HOLD_CYCLES = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic done_o
);
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign done_o = run_i && (cnt_q == LAST);
  assign cnt_en = run_i || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)      cnt_d = '0;
    else if (!done_o) cnt_d = cnt_q + CNT_W'(1);
    else             cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rgb_sense_poll_ctr.sv
`timescale 1ns/1ps
module rgb_sense_poll_ctr #(
  parameter int POLL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              busy_i,
  input  logic [POLL_W-1:0] limit_i,
  output logic              expire_o
);
  logic [POLL_W-1:0] cnt_q, cnt_d;
  logic [POLL_W:0]   eff_limit;
  logic [POLL_W:0]   cnt_next;
  logic              cnt_en;

  assign eff_limit = (limit_i == '0) ? (POLL_W+1)'(1) : {1'b0, limit_i};
  assign cnt_next  = {1'b0, cnt_q} + (POLL_W+1)'(1);
  assign expire_o  = busy_i && (cnt_next >= eff_limit);
  assign cnt_en    = clr_i || busy_i;

  always_comb begin
    if (clr_i) cnt_d = '0;
    else       cnt_d = cnt_next[POLL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rgb_sense_cmd_table.sv
`timescale 1ns/1ps
module rgb_sense_cmd_table
  import rgb_sense_pkg::*;
(
  input  logic [STEP_W-1:0] step_i,
  input  chan_bytes_t       size_i,
  input  chan_bytes_t       tint_i,
  output seq_cmd_t          cmd_o
);
  logic [1:0] ch;

  always_comb begin
    cmd_o = '{wr: 1'b1, addr: '0, data: SETUP_VAL};
    ch    = '0;
    if (step_i < STEP_SIZE0) begin
      cmd_o.addr = setup_addr(step_i[2:0]);
    end else if (step_i < STEP_TINT0) begin
      ch         = 2'(step_i - STEP_SIZE0);
      cmd_o.addr = REG_SIZE_R - {6'd0, ch};
      cmd_o.data = size_i[ch];
    end else if (step_i < STEP_TRIG) begin
      ch         = 2'(step_i - STEP_TINT0);
      cmd_o.addr = REG_TINT_R - {6'd0, ch};
      cmd_o.data = tint_i[ch];
    end else if (step_i == STEP_TRIG) begin
      cmd_o.addr = REG_ACQ;
      cmd_o.data = ACQ_GO;
    end else if (step_i == STEP_POLL) begin
      cmd_o.wr   = 1'b0;
      cmd_o.addr = REG_ACQ;
      cmd_o.data = '0;
    end else begin
      ch         = 2'(step_i - STEP_RD0);
      cmd_o.wr   = 1'b0;
      cmd_o.addr = REG_RES_R - {6'd0, ch};
      cmd_o.data = '0;
    end
  end
endmodule

// File: rtl/rgb_sense_ctrl.sv
`timescale 1ns/1ps
module rgb_sense_ctrl
  import rgb_sense_pkg::*;
#(
  parameter int RST_HOLD_CYCLES = 100,
  parameter int POLL_W          = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [POLL_W-1:0] poll_limit_i,
  input  logic [7:0]        pd_size_r_i,
  input  logic [7:0]        pd_size_g_i,
  input  logic [7:0]        pd_size_b_i,
  input  logic [7:0]        int_time_r_i,
  input  logic [7:0]        int_time_g_i,
  input  logic [7:0]        int_time_b_i,
  output logic              cmd_start_o,
  output logic              cmd_write_o,
  output logic [7:0]        cmd_addr_o,
  output logic [7:0]        cmd_wdata_o,
  input  logic              cmd_done_i,
  input  logic [7:0]        cmd_rdata_i,
  output logic              sensor_rst_n_o,
  output logic [7:0]        red_o,
  output logic [7:0]        green_o,
  output logic [7:0]        blue_o,
  output logic              rgb_valid_o,
  output logic              timeout_o
);
  localparam logic [STEP_W-1:0] STEP_SETUP_END = STEP_SIZE0 - STEP_W'(1);

  // reset release synchroniser
  logic [1:0] sync_q;
  logic       arst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign arst_n = sync_q[1];

  seq_state_t        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              init_q, init_d;
  logic              srst_q, srst_d;
  logic              valid_q, valid_d;
  logic              to_q, to_d;
  logic              cap_en, pub_en;
  logic [POLL_W-1:0] lim_q;
  chan_bytes_t       size_in, tint_in, size_q, tint_q;
  chan_bytes_t       shadow_q, pub_vec, out_q;
  seq_cmd_t          cmd;
  logic              rst_done, poll_expire;
  logic              wait_done, poll_busy, poll_clr, rd_fire;
  logic [1:0]        rd_ch;

  assign size_in = {pd_size_b_i, pd_size_g_i, pd_size_r_i};
  assign tint_in = {int_time_b_i, int_time_g_i, int_time_r_i};

  assign wait_done = (state_q == ST_WAIT) && cmd_done_i;
  assign poll_busy = wait_done && (step_q == STEP_POLL) && (cmd_rdata_i != '0);
  assign poll_clr  = wait_done && (step_q == STEP_TRIG);
  assign rd_fire   = wait_done && (step_q >= STEP_RD0);
  assign rd_ch     = 2'(step_q - STEP_RD0);

  rgb_sense_rst_timer #(.HOLD_CYCLES(RST_HOLD_CYCLES)) u_rst_timer (
    .clk    (clk),
    .rst_n  (arst_n),
    .run_i  (state_q == ST_RST),
    .done_o (rst_done)
  );

  rgb_sense_poll_ctr #(.POLL_W(POLL_W)) u_poll_ctr (
    .clk      (clk),
    .rst_n    (arst_n),
    .clr_i    (poll_clr),
    .busy_i   (poll_busy),
    .limit_i  (lim_q),
    .expire_o (poll_expire)
  );

  rgb_sense_cmd_table u_cmd_table (
    .step_i (step_q),
    .size_i (size_q),
    .tint_i (tint_q),
    .cmd_o  (cmd)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    init_d  = init_q;
    srst_d  = srst_q;
    valid_d = 1'b0;
    to_d    = 1'b0;
    cap_en  = 1'b0;
    pub_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          cap_en = 1'b1;
          if (init_q) begin
            state_d = ST_ISSUE;
            step_d  = STEP_SIZE0;
          end else begin
            state_d = ST_RST;
            step_d  = '0;
          end
        end
      end
      ST_RST: begin
        if (rst_done) begin
          state_d = ST_ISSUE;
          srst_d  = 1'b1;
        end
      end
      ST_ISSUE: state_d = ST_WAIT;
      ST_WAIT: begin
        if (cmd_done_i) begin
          if (poll_busy) begin
            if (poll_expire) begin
              to_d    = 1'b1;
              state_d = ST_IDLE;
            end else begin
              state_d = ST_ISSUE;
            end
          end else if (step_q == STEP_LAST) begin
            valid_d = 1'b1;
            pub_en  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            step_d  = step_q + STEP_W'(1);
            state_d = ST_ISSUE;
            if (step_q == STEP_SETUP_END) init_d = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      init_q  <= 1'b0;
      srst_q  <= 1'b0;
      valid_q <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      init_q  <= init_d;
      srst_q  <= srst_d;
      valid_q <= valid_d;
      to_q    <= to_d;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)     lim_q <= '0;
    else if (cap_en) lim_q <= poll_limit_i;
  end

  // per-channel capture, shadow and publish registers
  always_comb begin
    pub_vec             = shadow_q;
    pub_vec[NUM_CH-1]   = cmd_rdata_i;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
        size_q[c] <= '0;
        tint_q[c] <= '0;
      end else if (cap_en) begin
        size_q[c] <= size_in[c];
        tint_q[c] <= tint_in[c];
      end
    end

    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)                          shadow_q[c] <= '0;
      else if (rd_fire && (rd_ch == 2'(c))) shadow_q[c] <= cmd_rdata_i;
    end

    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)     out_q[c] <= '0;
      else if (pub_en) out_q[c] <= pub_vec[c];
    end
  end

  assign cmd_start_o    = (state_q == ST_ISSUE);
  assign cmd_write_o    = cmd.wr;
  assign cmd_addr_o     = cmd.addr;
  assign cmd_wdata_o    = cmd.data;
  assign sensor_rst_n_o = srst_q;
  assign red_o          = out_q[0];
  assign green_o        = out_q[1];
  assign blue_o         = out_q[2];
  assign rgb_valid_o    = valid_q;
  assign timeout_o      = to_q;
endmodule

// File: rtl/rgb_sense_ctrl_chk.sv
`timescale 1ns/1ps
module rgb_sense_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_start_o,
  input logic       cmd_done_i,
  input logic       cmd_write_o,
  input logic [7:0] cmd_addr_o,
  input logic [7:0] cmd_wdata_o,
  input logic       sensor_rst_n_o,
  input logic [7:0] red_o,
  input logic [7:0] green_o,
  input logic [7:0] blue_o,
  input logic       rgb_valid_o,
  input logic       timeout_o
);
  logic pend_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           pend_q <= 1'b0;
    else if (cmd_start_o) pend_q <= 1'b1;
    else if (cmd_done_i)  pend_q <= 1'b0;
  end

  assert_req_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start_o |=> !cmd_start_o);
  assert_single_outstanding_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> !cmd_start_o);
  assert_fields_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> ($stable(cmd_addr_o) && $stable(cmd_write_o) && $stable(cmd_wdata_o)));
  assert_no_cmd_in_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sensor_rst_n_o |-> !cmd_start_o);
  assert_rst_stays_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sensor_rst_n_o |=> sensor_rst_n_o);
  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rgb_valid_o |=> !rgb_valid_o);
  assert_rgb_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rgb_valid_o |-> ($stable(red_o) && $stable(green_o) && $stable(blue_o)));
  assert_timeout_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> !timeout_o);
  assert_end_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(timeout_o && rgb_valid_o));
endmodule

bind rgb_sense_ctrl rgb_sense_ctrl_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cmd_start_o    (cmd_start_o),
  .cmd_done_i     (cmd_done_i),
  .cmd_write_o    (cmd_write_o),
  .cmd_addr_o     (cmd_addr_o),
  .cmd_wdata_o    (cmd_wdata_o),
  .sensor_rst_n_o (sensor_rst_n_o),
  .red_o          (red_o),
  .green_o        (green_o),
  .blue_o         (blue_o),
  .rgb_valid_o    (rgb_valid_o),
  .timeout_o      (timeout_o)
);

// File: tb/rgb_sense_ctrl_tb.sv
`timescale 1ns/1ps
module rgb_sense_ctrl_tb;
  localparam int RST_CYC = 20;
  localparam int POLL_W  = 16;
  localparam int WD_LIMIT = 50000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic [POLL_W-1:0] poll_limit_i = '0;
  logic [7:0]        pd_r = 8'h0F, pd_g = 8'h07, pd_b = 8'h03;
  logic [7:0]        ti_r = 8'h05, ti_g = 8'h09, ti_b = 8'h0C;
  logic              cmd_start_o, cmd_write_o, cmd_done_i = 1'b0;
  logic [7:0]        cmd_addr_o, cmd_wdata_o, cmd_rdata_i = 8'h00;
  logic              sensor_rst_n_o, rgb_valid_o, timeout_o;
  logic [7:0]        red_o, green_o, blue_o;

  always #5 clk = ~clk;

  rgb_sense_ctrl #(.RST_HOLD_CYCLES(RST_CYC), .POLL_W(POLL_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .poll_limit_i(poll_limit_i),
    .pd_size_r_i(pd_r), .pd_size_g_i(pd_g), .pd_size_b_i(pd_b),
    .int_time_r_i(ti_r), .int_time_g_i(ti_g), .int_time_b_i(ti_b),
    .cmd_start_o(cmd_start_o), .cmd_write_o(cmd_write_o),
    .cmd_addr_o(cmd_addr_o), .cmd_wdata_o(cmd_wdata_o),
    .cmd_done_i(cmd_done_i), .cmd_rdata_i(cmd_rdata_i),
    .sensor_rst_n_o(sensor_rst_n_o), .red_o(red_o), .green_o(green_o),
    .blue_o(blue_o), .rgb_valid_o(rgb_valid_o), .timeout_o(timeout_o)
  );

  typedef struct {
    bit       wr;
    bit [7:0] addr;
    bit [7:0] data;
    string    tag;
  } exp_cmd_t;

  exp_cmd_t q[$];
  int  vectors = 0, miscompares = 0, cyc = 0, runs = 0;
  bit  m_busy = 0, m_out = 0, m_init = 0, m_srst = 0, m_to = 0;
  int  m_rst_left = 0;
  bit [7:0] m_pub_r = 0, m_pub_g = 0, m_pub_b = 0;
  bit [7:0] m_exp_r = 0, m_exp_g = 0, m_exp_b = 0;
  // engine model
  bit  eng_pend = 0, eng_wr = 0, inject = 0;
  bit [7:0] eng_addr = 0;
  int  eng_wait = 0, lat = 2, cfg_busy = 0, busy_left = 0;
  bit [7:0] sens_r = 8'h11, sens_g = 8'h22, sens_b = 8'h33;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  function automatic exp_cmd_t mk(bit wr, bit [7:0] a, bit [7:0] d, string t);
    exp_cmd_t e;
    e.wr = wr; e.addr = a; e.data = d; e.tag = t;
    return e;
  endfunction

  task automatic plan_run();
    int lim, polls;
    bit [7:0] setup_regs[5] = '{8'h03, 8'h04, 8'h0C, 8'h0D, 8'h0E};
    if (!m_init) begin
      foreach (setup_regs[i]) q.push_back(mk(1, setup_regs[i], 8'h01, "R3"));
    end
    q.push_back(mk(1, 8'h0B, pd_r, m_init ? "R9" : "R4"));
    q.push_back(mk(1, 8'h0A, pd_g, "R4"));
    q.push_back(mk(1, 8'h09, pd_b, "R4"));
    q.push_back(mk(1, 8'h11, ti_r, "R4"));
    q.push_back(mk(1, 8'h10, ti_g, "R4"));
    q.push_back(mk(1, 8'h0F, ti_b, "R4"));
    q.push_back(mk(1, 8'h02, 8'h02, "R5"));
    lim = (poll_limit_i == 0) ? 1 : int'(poll_limit_i);
    m_to = (cfg_busy >= lim);
    polls = m_to ? lim : cfg_busy + 1;
    for (int i = 0; i < polls; i++) q.push_back(mk(0, 8'h02, 8'h00, m_to ? "R6" : "R5"));
    if (!m_to) begin
      q.push_back(mk(0, 8'h44, 8'h00, "R7"));
      q.push_back(mk(0, 8'h43, 8'h00, "R7"));
      q.push_back(mk(0, 8'h42, 8'h00, "R7"));
    end
    m_exp_r = sens_r; m_exp_g = sens_g; m_exp_b = sens_b;
  endtask

  // reference model and per-clock comparison, sampled after the edge
  always @(posedge clk) begin
    bit exp_start, exp_valid, exp_to, was_busy;
    exp_cmd_t e;
    #1;
    cyc++;
    exp_start = 0; exp_valid = 0; exp_to = 0;
    if (cyc > WD_LIMIT) begin
      miscompares++;
      $display("FAIL R8 watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
    if (!rst_n) begin
      m_busy = 0; m_out = 0; m_init = 0; m_srst = 0; m_rst_left = 0;
      m_pub_r = 0; m_pub_g = 0; m_pub_b = 0;
      q.delete();
      chk("R1", "reset pin", sensor_rst_n_o, 0);
      chk("R1", "request", cmd_start_o, 0);
      chk("R1", "valid", rgb_valid_o, 0);
      chk("R1", "timeout", timeout_o, 0);
      chk("R1", "colours", {red_o, green_o, blue_o}, 0);
    end else begin
      was_busy = m_busy;
      if (m_rst_left > 0) begin
        m_rst_left--;
        if (m_rst_left == 0) begin m_srst = 1; exp_start = 1; end
      end
      if (m_out && cmd_done_i) begin
        m_out = 0;
        if (q.size() == 0) begin
          m_busy = 0;
          if (m_to) exp_to = 1;
          else begin
            exp_valid = 1;
            m_pub_r = m_exp_r; m_pub_g = m_exp_g; m_pub_b = m_exp_b;
          end
        end else exp_start = 1;
      end else if (!m_busy && start_i) begin
        m_busy = 1;
        runs++;
        plan_run();
        if (!m_init) begin m_init = 1; m_rst_left = RST_CYC; end
        else exp_start = 1;
      end
      chk((start_i && was_busy) ? "R10" : "R8", "request timing", cmd_start_o, exp_start);
      if (cmd_start_o) begin
        if (q.size() == 0) chk("R8", "unexpected request", 1, 0);
        else begin
          e = q.pop_front();
          chk(e.tag, "cmd write flag", cmd_write_o, e.wr);
          chk(e.tag, "cmd address", cmd_addr_o, e.addr);
          if (e.wr) chk(e.tag, "cmd data", cmd_wdata_o, e.data);
          m_out = 1;
          eng_pend = 1; eng_wait = lat; eng_wr = cmd_write_o; eng_addr = cmd_addr_o;
        end
      end
      chk(runs > 1 ? "R9" : "R2", "sensor reset pin", sensor_rst_n_o, m_srst);
      chk("R7", "valid strobe", rgb_valid_o, exp_valid);
      chk("R6", "timeout strobe", timeout_o, exp_to);
      chk("R7", "colour outputs", {red_o, green_o, blue_o}, {m_pub_r, m_pub_g, m_pub_b});
    end
  end

  // bus engine model, driven away from the active edge
  always @(negedge clk) begin
    cmd_done_i = 0;
    if (eng_pend) begin
      eng_wait--;
      if (eng_wait <= 0) begin
        eng_pend = 0;
        cmd_done_i = 1;
        if (eng_wr) begin
          cmd_rdata_i = 8'hA5;
          if (eng_addr == 8'h02) busy_left = cfg_busy;
        end else begin
          case (eng_addr)
            8'h02: begin
              cmd_rdata_i = (busy_left > 0) ? 8'h02 : 8'h00;
              if (busy_left > 0) busy_left--;
            end
            8'h44: cmd_rdata_i = sens_r;
            8'h43: cmd_rdata_i = sens_g;
            8'h42: cmd_rdata_i = sens_b;
            default: cmd_rdata_i = 8'hEE;
          endcase
        end
      end
    end else if (inject) begin
      inject = 0;
      cmd_done_i = 1;
      cmd_rdata_i = 8'h77;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_end();
    @(negedge clk);
    while (m_busy) @(negedge clk);
  endtask

  task automatic one_run(input bit disturb);
    @(negedge clk); start_i = 1;
    @(negedge clk); start_i = 0;
    if (disturb) begin
      // R4 capture: change sensitivity inputs after acceptance
      pd_r = 8'h01; pd_g = 8'h01; pd_b = 8'h01;
      ti_r = 8'h00; ti_g = 8'h00; ti_b = 8'h00;
      idle(30);
      // R10: start mid-run must be ignored
      start_i = 1; idle(3); start_i = 0;
    end
    wait_end();
  endtask

  initial begin
    idle(5);
    rst_n = 1;
    idle(5);
    // inject a stray completion while idle (R8)
    inject = 1; idle(4);
    // run 1: bring-up, three busy polls, sensitivity changed mid-run
    poll_limit_i = 10; cfg_busy = 3; lat = 2;
    one_run(1);
    idle(3);
    inject = 1; idle(4);
    // runs 2 and 3: start held high across the end of run 2 (R10)
    pd_r = 8'h07; pd_g = 8'h0F; pd_b = 8'h03; ti_r = 8'h0E; ti_g = 8'h02; ti_b = 8'h08;
    sens_r = 8'h5A; sens_g = 8'h3C; sens_b = 8'h7E;
    poll_limit_i = 5; cfg_busy = 0; lat = 5;
    begin
      int r0;
      r0 = runs;
      start_i = 1;
      while (runs < r0 + 2) @(negedge clk);
      start_i = 0;
    end
    wait_end();
    idle(2);
    // run 4: timeout after three busy polls (R6)
    poll_limit_i = 3; cfg_busy = 7; lat = 3;
    sens_r = 8'h01; sens_g = 8'h02; sens_b = 8'h03;
    one_run(0);
    // run 5: limit zero acts as one (R6)
    poll_limit_i = 0; cfg_busy = 1;
    one_run(0);
    // run 6: sensor clears on the last allowed poll (R5)
    poll_limit_i = 3; cfg_busy = 2;
    sens_r = 8'h6B; sens_g = 8'h00; sens_b = 8'hFF;
    one_run(0);
    idle(5);
    chk("R8", "leftover expected commands", q.size(), 0);
    chk("R7", "published red after run 6", red_o, 8'h6B);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule